// File: doc/BRIEF.md
# Interrupt Request and Service Core

This block is the request and service core of an eight-line interrupt controller. It watches the interrupt pins and latches a request when a pin goes from low to high, provided that line is unmasked at that moment. It keeps a pending-request register and an in-service register. When a request can be served without being shadowed by work already in service, it sends the processor a one-cycle interrupt pulse. A command decoder next to it supplies the mask, the vector base, the cascade bits, the automatic end-of-interrupt flag and end-of-interrupt commands.

The processor acknowledges through a valid/ready request channel. The block then returns the vector on a valid/ready response channel. The vector is the base with the serviced line number ORed into its low bits. A flag on the response says that a slave controller on that line must supply the vector instead. Only one cascade level is handled.

Back-pressure works as follows. The block holds a response until `vec_ready_i` is seen high at a clock edge. While it holds one, `ack_ready_o` stays low only if `vec_ready_i` is low. An acknowledge counts only on an edge where both `ack_valid_i` and `ack_ready_o` are high.

Top module: `pic_service_core`

## Requirements
- R1: A request is recorded only on a low-to-high change of its pin, as seen between two consecutive clock edges. A pin that stays high raises no further request until it has gone low and then high again.
- R2: A pin edge is dropped when its mask bit (bit i of `mask_i` for line i) is 1 at that edge. Clearing the mask afterwards does not bring the dropped request back.
- R3: Among pending requests, the highest line number wins. Line 7 outranks line 0.
- R4: `int_o` pulses high for exactly one cycle when a newly recorded request has no in-service bit set at its own line or any higher line. Otherwise it stays low.
- R5: An accepted acknowledge with requests pending clears the pending bit of the winning line. When automatic EOI is off, it also sets that line's in-service bit.
- R6: With `auto_eoi_i` high, an acknowledge leaves the serviced line's in-service bit clear. If requests are still pending, the highest of them is re-evaluated as in R4 and may pulse `int_o`.
- R7: The response carries `vec_base_i | line`. `vec_slave_o` is 1 exactly when `slave_present_i` is high and `cascade_i[line]` is 1.
- R8: A specific EOI (`eoi_nonspec_i` = 0) clears the in-service bit given by `eoi_line_i`. The highest pending request is then re-evaluated as in R4.
- R9: A non-specific EOI (`eoi_nonspec_i` = 1) clears the highest set in-service bit.
- R10: An acknowledge with no request pending returns `vec_base_i | 7` with `vec_slave_o` = 0. It changes neither the pending register nor the in-service register.
- R11: A response stays valid and unchanged until it is accepted. No new acknowledge is accepted while a response is held and `vec_ready_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_pin_i | input | 8 | Interrupt pins, bit i is line i |
| mask_i | input | 8 | Mask, 1 drops edges on that line |
| cascade_i | input | 8 | 1 marks a line driven by a slave controller |
| slave_present_i | input | 1 | A slave controller is attached |
| auto_eoi_i | input | 1 | Automatic end-of-interrupt on acknowledge |
| vec_base_i | input | 8 | Vector base, line number ORed in |
| eoi_valid_i | input | 1 | One-cycle EOI command |
| eoi_nonspec_i | input | 1 | 1 = non-specific EOI, 0 = specific |
| eoi_line_i | input | 3 | Line for a specific EOI |
| ack_valid_i | input | 1 | Acknowledge request valid |
| ack_ready_o | output | 1 | Acknowledge request can be taken |
| vec_valid_o | output | 1 | Response valid |
| vec_ready_i | input | 1 | Response consumer ready |
| vec_data_o | output | 8 | Vector |
| vec_slave_o | output | 1 | Slave must supply the vector |
| int_o | output | 1 | Interrupt pulse to the processor |
| irr_o | output | 8 | Pending-request register |
| isr_o | output | 8 | In-service register |

## Verification
A pin edge that is driven between two clock edges shows in `irr_o` after the next rising edge. The interrupt pulse it causes is high for that same following cycle. An accepted acknowledge updates `irr_o`, `isr_o` and the response one edge later, and any re-evaluation pulse from automatic EOI appears in that same cycle. An EOI command changes `isr_o` one edge after it is applied, together with its re-evaluation pulse. The bench drives its inputs just after a falling edge and reads the outputs there. It counts interrupt pulses on every falling edge, so the count for each stimulus is complete before it is checked.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int DEF_LINES = 8;
  localparam int DEF_VW    = 8;

  typedef enum logic {
    EOI_SPECIFIC = 1'b0,
    EOI_NONSPEC  = 1'b1
  } eoi_kind_e;
endpackage

// File: rtl/pic_edge_gate.sv
module pic_edge_gate #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] new_req_o
);
  logic [N-1:0] prev_q;

  for (genvar g = 0; g < N; g++) begin : g_line
    // A line asks for service only on a fresh rise while unmasked.
    assign new_req_o[g] = pin_i[g] & ~prev_q[g] & ~mask_i[g];

    always_ff @(posedge clk) begin
      if (!rst_n) prev_q[g] <= 1'b0;
      else        prev_q[g] <= pin_i[g];
    end
  end
endmodule

// File: rtl/pic_prio_enc.sv
module pic_prio_enc #(
  parameter int N  = 8,
  localparam int LW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [LW-1:0] top_o
);
  always_comb begin
    any_o = 1'b0;
    top_o = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        top_o = LW'(i);
      end
    end
  end
endmodule

// File: rtl/pic_shadow.sv
module pic_shadow #(
  parameter int N  = 8,
  localparam int LW = $clog2(N)
) (
  input  logic [N-1:0]  isr_i,
  input  logic [LW-1:0] line_i,
  output logic          clear_o
);
  // clear_o is high when no in-service bit sits at line_i or above.
  always_comb begin
    clear_o = 1'b1;
    for (int i = 0; i < N; i++) begin
      if (isr_i[i] && (LW'(i) >= line_i)) clear_o = 1'b0;
    end
  end
endmodule

// File: rtl/pic_ack_port.sv
module pic_ack_port #(
  parameter int VW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [VW-1:0] vec_i,
  input  logic          slave_i,
  input  logic          ready_i,
  output logic          take_ok_o,
  output logic          valid_o,
  output logic [VW-1:0] vec_o,
  output logic          slave_o
);
  assign take_ok_o = ~valid_o | ready_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      vec_o   <= '0;
      slave_o <= 1'b0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      vec_o   <= vec_i;
      slave_o <= slave_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/pic_service_core.sv
module pic_service_core
  import pic_pkg::*;
#(
  parameter int N  = DEF_LINES,
  parameter int VW = DEF_VW,
  localparam int LW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  irq_pin_i,
  input  logic [N-1:0]  mask_i,
  input  logic [N-1:0]  cascade_i,
  input  logic          slave_present_i,
  input  logic          auto_eoi_i,
  input  logic [VW-1:0] vec_base_i,
  input  logic          eoi_valid_i,
  input  logic          eoi_nonspec_i,
  input  logic [LW-1:0] eoi_line_i,
  input  logic          ack_valid_i,
  output logic          ack_ready_o,
  output logic          vec_valid_o,
  input  logic          vec_ready_i,
  output logic [VW-1:0] vec_data_o,
  output logic          vec_slave_o,
  output logic          int_o,
  output logic [N-1:0]  irr_o,
  output logic [N-1:0]  isr_o
);
  logic [N-1:0]  irr_q, isr_q, irr_nx, isr_nx;
  logic [N-1:0]  new_req, ack_hot, eoi_clr, auto_clr, isr_set;
  logic          irr_any, isr_any, new_any, nx_any;
  logic [LW-1:0] irr_top, isr_top, new_top, nx_top;
  logic          new_clear, nx_clear;
  logic          ack_fire, ack_hit, reeval, fire;
  logic [VW-1:0] vec_nx;
  logic          slave_nx;
  logic          int_q;
  eoi_kind_e     eoi_kind;

  pic_edge_gate #(.N(N)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin_i(irq_pin_i), .mask_i(mask_i),
    .new_req_o(new_req)
  );

  pic_prio_enc #(.N(N)) u_enc_irr (.req_i(irr_q),   .any_o(irr_any), .top_o(irr_top));
  pic_prio_enc #(.N(N)) u_enc_isr (.req_i(isr_q),   .any_o(isr_any), .top_o(isr_top));
  pic_prio_enc #(.N(N)) u_enc_new (.req_i(new_req), .any_o(new_any), .top_o(new_top));
  pic_prio_enc #(.N(N)) u_enc_nx  (.req_i(irr_nx),  .any_o(nx_any),  .top_o(nx_top));

  pic_shadow #(.N(N)) u_sh_new (.isr_i(isr_nx), .line_i(new_top), .clear_o(new_clear));
  pic_shadow #(.N(N)) u_sh_nx  (.isr_i(isr_nx), .line_i(nx_top),  .clear_o(nx_clear));

  assign ack_fire = ack_valid_i & ack_ready_o;
  assign ack_hit  = ack_fire & irr_any;
  assign eoi_kind = eoi_kind_e'(eoi_nonspec_i);

  always_comb begin
    ack_hot  = ack_hit ? (N'(1) << irr_top) : '0;
    eoi_clr  = '0;
    if (eoi_valid_i) begin
      if (eoi_kind == EOI_NONSPEC) eoi_clr = isr_any ? (N'(1) << isr_top) : '0;
      else                         eoi_clr = N'(1) << eoi_line_i;
    end
    auto_clr = auto_eoi_i ? ack_hot : '0;
    isr_set  = auto_eoi_i ? '0 : ack_hot;
    isr_nx   = (isr_q & ~eoi_clr & ~auto_clr) | isr_set;
    irr_nx   = (irr_q | new_req) & ~ack_hot;
    reeval   = eoi_valid_i | (ack_hit & auto_eoi_i);
    fire     = (new_any & new_clear) | (reeval & nx_any & nx_clear);
  end

  always_comb begin
    if (irr_any) begin
      vec_nx   = vec_base_i | VW'(irr_top);
      slave_nx = slave_present_i & cascade_i[irr_top];
    end else begin
      vec_nx   = vec_base_i | VW'(N - 1);
      slave_nx = 1'b0;
    end
  end

  pic_ack_port #(.VW(VW)) u_port (
    .clk(clk), .rst_n(rst_n), .load_i(ack_fire), .vec_i(vec_nx),
    .slave_i(slave_nx), .ready_i(vec_ready_i), .take_ok_o(ack_ready_o),
    .valid_o(vec_valid_o), .vec_o(vec_data_o), .slave_o(vec_slave_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr_q <= '0;
      isr_q <= '0;
      int_q <= 1'b0;
    end else begin
      irr_q <= irr_nx;
      isr_q <= isr_nx;
      int_q <= fire;
    end
  end

  assign int_o = int_q;
  assign irr_o = irr_q;
  assign isr_o = isr_q;
endmodule

// File: rtl/pic_service_chk.sv
module pic_service_chk #(
  parameter int N  = 8,
  parameter int VW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  mask_i,
  input logic          auto_eoi_i,
  input logic [VW-1:0] vec_base_i,
  input logic          eoi_valid_i,
  input logic          ack_valid_i,
  input logic          ack_ready_o,
  input logic          vec_valid_o,
  input logic          vec_ready_i,
  input logic [VW-1:0] vec_data_o,
  input logic          vec_slave_o,
  input logic [N-1:0]  irr_o,
  input logic [N-1:0]  isr_o
);
  logic ack_fire;
  assign ack_fire = ack_valid_i & ack_ready_o;

  AST_MASK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> ((irr_o & ~$past(irr_o) & $past(mask_i)) == '0)); // R2

  AST_MASK_DROPS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_fire |=> ((irr_o & ~$past(irr_o) & $past(mask_i)) == '0)); // R2

  AST_ACK_CLEARS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && (irr_o != '0)) |=> ($countones($past(irr_o) & ~irr_o) == 1)); // R5

  AST_ISR_SET_BY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ((isr_o & ~$past(isr_o)) != '0) |-> ($past(ack_fire) && !$past(auto_eoi_i))); // R5

  AST_ISR_ONE_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> $onehot0(isr_o & ~$past(isr_o))); // R6

  AST_EMPTY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && (irr_o == '0) && !eoi_valid_i) |=>
      (vec_data_o == ($past(vec_base_i) | VW'(N - 1))) && !vec_slave_o
      && (isr_o == $past(isr_o))); // R10

  AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid_o && !vec_ready_i) |=>
      (vec_valid_o && $stable(vec_data_o) && $stable(vec_slave_o))); // R11
endmodule

bind pic_service_core pic_service_chk #(.N(N), .VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mask_i(mask_i), .auto_eoi_i(auto_eoi_i),
  .vec_base_i(vec_base_i), .eoi_valid_i(eoi_valid_i),
  .ack_valid_i(ack_valid_i), .ack_ready_o(ack_ready_o),
  .vec_valid_o(vec_valid_o), .vec_ready_i(vec_ready_i),
  .vec_data_o(vec_data_o), .vec_slave_o(vec_slave_o),
  .irr_o(irr_o), .isr_o(isr_o)
);

// File: tb/sim_pic_service_core.sv
module sim_pic_service_core;
  localparam int CLK_PERIOD = 10;
  localparam int NROWS = 6;
  // fields: pins, mask, cascade, expected irr, expected vector, expected slave
  localparam logic [47:0] TBL [NROWS] = '{
    {8'h01, 8'h00, 8'h00, 8'h01, 8'h20, 8'h00},
    {8'h81, 8'h00, 8'h00, 8'h81, 8'h27, 8'h00},
    {8'hFF, 8'h80, 8'h00, 8'h7F, 8'h26, 8'h00},
    {8'h0C, 8'h04, 8'h08, 8'h08, 8'h23, 8'h01},
    {8'h30, 8'h00, 8'h10, 8'h30, 8'h25, 8'h00},
    {8'hF0, 8'hF0, 8'h00, 8'h00, 8'h27, 8'h00}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] pins = '0, mask = '0, casc = '0, base = 8'h20;
  logic slave_p = 1'b1, auto_e = 1'b0;
  logic eoi_v = 1'b0, eoi_ns = 1'b0;
  logic [2:0] eoi_l = '0;
  logic ack_v = 1'b0, vec_r = 1'b0;
  logic ack_r, vec_v, vec_s, intr;
  logic [7:0] vec_d, irr, isr;

  int n_chk = 0, n_bad = 0, pulses = 0, base_p = 0;
  logic done = 1'b0;
  logic [7:0] got_vec;
  logic got_slave;

  always #(CLK_PERIOD/2) clk = ~clk;

  pic_service_core u0 (
    .clk(clk), .rst_n(rst_n), .irq_pin_i(pins), .mask_i(mask), .cascade_i(casc),
    .slave_present_i(slave_p), .auto_eoi_i(auto_e), .vec_base_i(base),
    .eoi_valid_i(eoi_v), .eoi_nonspec_i(eoi_ns), .eoi_line_i(eoi_l),
    .ack_valid_i(ack_v), .ack_ready_o(ack_r), .vec_valid_o(vec_v),
    .vec_ready_i(vec_r), .vec_data_o(vec_d), .vec_slave_o(vec_s),
    .int_o(intr), .irr_o(irr), .isr_o(isr)
  );

  always @(negedge clk) if (rst_n && intr) pulses <= pulses + 1;

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; pins = '0; mask = '0; casc = '0; auto_e = 1'b0;
    eoi_v = 1'b0; ack_v = 1'b0; vec_r = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic set_pins(input logic [7:0] v);
    pins = v; step();
  endtask

  task automatic do_ack();
    ack_v = 1'b1; vec_r = 1'b0; step();
    ack_v = 1'b0;
    got_vec = vec_d; got_slave = vec_s;
    vec_r = 1'b1; step();
    vec_r = 1'b0;
  endtask

  task automatic do_eoi(input logic ns, input logic [2:0] l);
    eoi_v = 1'b1; eoi_ns = ns; eoi_l = l; step();
    eoi_v = 1'b0;
  endtask

  function automatic logic [7:0] top_hot(input logic [7:0] v);
    logic [7:0] r = '0;
    for (int i = 0; i < 8; i++) if (v[i]) r = 8'(1) << i;
    return r;
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // reset state
    rst_n = 1'b0; repeat (3) step();
    chk("reset irr", irr, 0);
    chk("reset isr", isr, 0);
    chk("reset int/valid/ready", {intr, vec_v, ack_r}, 3'b001);

    // table: priority, masking, vector and cascade flag
    for (int r = 0; r < NROWS; r++) begin
      logic [7:0] ei, hot;
      do_reset();
      mask = TBL[r][39:32]; casc = TBL[r][31:24];
      set_pins(TBL[r][47:40]);
      ei = TBL[r][23:16];
      chk($sformatf("R2 R1 row%0d irr", r), irr, ei);
      do_ack();
      chk($sformatf("R3 R7 row%0d vector", r), got_vec, TBL[r][15:8]);
      chk($sformatf("R7 row%0d slave flag", r), got_slave, TBL[r][0]);
      hot = top_hot(ei);
      chk($sformatf("R5 R10 row%0d isr", r), isr, hot);
      chk($sformatf("R5 row%0d irr after ack", r), irr, ei & ~hot);
    end

    // R1: held pin does not re-request
    do_reset();
    set_pins(8'h01);
    do_ack();
    do_eoi(1'b0, 3'd0);
    repeat (3) step();
    chk("R1 held pin no new request", irr, 8'h00);
    set_pins(8'h00); set_pins(8'h01);
    chk("R1 new rise re-requests", irr, 8'h01);

    // R2: unmasking later does not revive
    do_reset();
    mask = 8'h04; set_pins(8'h04);
    mask = 8'h00; repeat (2) step();
    chk("R2 dropped edge stays dropped", irr, 8'h00);

    // R4 / R8: shadowing and specific EOI
    do_reset();
    base_p = pulses;
    set_pins(8'h20); step();
    chk("R4 unshadowed pulse", pulses - base_p, 1);
    do_ack();
    chk("R5 isr line5", isr, 8'h20);
    base_p = pulses;
    set_pins(8'h28); step();
    chk("R4 lower line shadowed irr", irr, 8'h08);
    chk("R4 lower line no pulse", pulses - base_p, 0);
    set_pins(8'h68); step();
    chk("R4 higher line one pulse", pulses - base_p, 1);
    do_ack();
    chk("R3 vector line6", got_vec, 8'h26);
    chk("R5 isr lines 6,5", isr, 8'h60);
    base_p = pulses;
    do_eoi(1'b0, 3'd6); step();
    chk("R8 specific EOI isr", isr, 8'h20);
    chk("R8 still shadowed no pulse", pulses - base_p, 0);
    do_eoi(1'b0, 3'd5); step();
    chk("R8 EOI isr cleared", isr, 8'h00);
    chk("R8 re-evaluation pulse", pulses - base_p, 1);

    // R9 / R10: non-specific EOI and empty acknowledge
    do_reset();
    set_pins(8'h04); do_ack();
    set_pins(8'h44); do_ack();
    chk("R9 setup isr", isr, 8'h44);
    do_eoi(1'b1, 3'd0);
    chk("R9 non-specific clears highest", isr, 8'h04);
    do_ack();
    chk("R10 empty vector", got_vec, 8'h27);
    chk("R10 empty slave flag", got_slave, 1'b0);
    chk("R10 state unchanged", {irr, isr}, {8'h00, 8'h04});

    // R6: automatic EOI
    do_reset();
    auto_e = 1'b1;
    base_p = pulses;
    set_pins(8'h12); step();
    chk("R6 irr both", irr, 8'h12);
    do_ack();
    chk("R6 vector line4", got_vec, 8'h24);
    chk("R6 isr stays clear", isr, 8'h00);
    chk("R6 irr remaining", irr, 8'h02);
    chk("R6 re-evaluation pulse", pulses - base_p, 2);

    // R11: back-pressure on the response
    do_reset();
    set_pins(8'h02); step();
    ack_v = 1'b1; vec_r = 1'b0; step();
    ack_v = 1'b0;
    chk("R11 response valid", {vec_v, ack_r}, 2'b10);
    repeat (3) step();
    chk("R11 held vector", {vec_v, vec_d}, {1'b1, 8'h21});
    vec_r = 1'b1; step();
    vec_r = 1'b0;
    chk("R11 released", vec_v, 1'b0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule